// File: doc/BRIEF.md
# UART receive status and error-clear

This block sits between the deserializer of a UART receiver and the register port of the bus. Each character that arrives on a one-cycle valid strobe is stored together with three flags of its own: framing error, parity-error-or-address marker, and break. The flags are computed and fixed when the character arrives. Characters are buffered in a receive FIFO, or in a single holding slot when the FIFO is switched off. Software pops a character by reading the data register. That read returns the character and its flags together, and it also copies the flags into a receive status register. Software may read the status register afterwards.

Overrun happens when a character arrives while the buffer is full. It is not tied to reads: the overrun status bit rises as soon as the condition occurs, and the incoming character is dropped. A write of any value to the status address clears all four status bits. In nine-bit mode the parity flag does not report parity. It carries the received ninth bit, which tells address characters apart from data characters.

Top module: `uart_rx_status`

## Requirements
- R1: After synchronous reset all four status bits are 0, the buffer is empty, and a read of the data register returns 0.
- R2: Data-register reads return characters in arrival order. The character is in bits 7:0, framing error in bit 8, parity/address flag in bit 9, break in bit 10 and the current overrun status in bit 11.
- R3: Status bits 2:0 are framing (bit 0), parity/address (bit 1) and break (bit 2) of the character most recently popped by a data read, never those of the character now at the head. They change only when a data read pops a character, or when the error-clear write occurs.
- R4: A character that arrives while the buffer is full, with no pop in the same cycle, is discarded and the stored characters are kept. Status bit 3 (overrun) reads 1 from the next cycle on, with no data read needed. A pop in the same cycle makes room, so no overrun occurs.
- R5: A write to byte offset 0x4 clears status bits 3:0 whatever the write data. An overrun detected in the same cycle as the clear still sets bit 3.
- R6: With nine-bit mode off and parity checking enabled, the parity flag is 1 when the received parity bit differs from the expected bit. The expected bit is the XOR of the 8 data bits for even selection and its inverse for odd selection. With parity checking disabled the flag is 0.
- R7: With stick parity on (nine-bit mode off, parity enabled), the expected parity bit is the constant 0 when even selection is 1 and the constant 1 when even selection is 0.
- R8: With nine-bit mode on, the parity flag equals the received ninth bit (1 = address, 0 = data), whatever the parity settings.
- R9: The flags stored with a character are computed from the configuration at arrival. A later configuration change does not alter them.
- R10: Read bits 31:12 of the data register and bits 31:4 of the status register are 0. A read of any other offset returns 0. Writes to offsets other than 0x4 change neither the status nor the buffer.
- R11: With the FIFO disabled the buffer holds one character. A second character that arrives before the first is read causes an overrun.
- R12: A data read of an empty buffer returns 0 in bits 10:0 and the overrun status in bit 11. It leaves the status register and the buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1: buffer of DEPTH characters, 0: one holding slot |
| cfg_nine_bit | input | 1 | Ninth bit is an address marker instead of parity |
| cfg_par_en | input | 1 | Parity checking enabled |
| cfg_par_even | input | 1 | Even parity selection (stick value select in stick mode) |
| cfg_par_stick | input | 1 | Stick parity |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received character |
| rx_extra | input | 1 | Received parity / ninth bit |
| rx_frame_err | input | 1 | Framing error indication for this character |
| rx_break | input | 1 | Break indication for this character |
| reg_addr | input | ADDR_W | Byte address: 0x0 data, 0x4 status/error clear |
| reg_rd_en | input | 1 | Read strobe; a data read pops the buffer |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (ignored) |
| reg_rdata | output | 32 | Combinational read data for reg_addr |

## Verification
The hardest cases to reach from the ports are the same-edge collisions on a full buffer. In one, a pop and an arriving character land on the same edge, so no overrun may be reported. In the other, an overrun and an error-clear write land on the same edge, and bit 3 must stay set. The bench fills the buffer to exactly its depth through the character strobe. It then drives the read strobe or the clear write in the same cycle as a further character, and checks both the status and the later drain order. A sweep of all 256 characters under all sixteen combinations of the parity and nine-bit controls compares each popped flag with a parity computed arithmetically in the bench.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    localparam int DW       = 8;
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 4;

    typedef struct packed {
        logic brk;
        logic par;
        logic frm;
    } rxs_flags_t;

    typedef struct packed {
        rxs_flags_t     flags;
        logic [DW-1:0]  data;
    } rxs_entry_t;

    typedef struct packed {
        logic       ovr;
        rxs_flags_t flags;
    } rxs_status_t;

    typedef enum logic [1:0] {
        REG_DATA,
        REG_STAT,
        REG_NONE
    } rxs_reg_e;

    // Expected parity bit for the received character.
    function automatic logic expected_parity(input logic [DW-1:0] d,
                                             input logic even,
                                             input logic stick);
        logic b;
        if (stick)
            b = ~even;
        else if (even)
            b = ^d;
        else
            b = ~(^d);
        return b;
    endfunction

    // Parity-error / address flag stored with a character.
    function automatic logic parity_flag(input logic [DW-1:0] d,
                                         input logic extra,
                                         input logic nine,
                                         input logic pen,
                                         input logic even,
                                         input logic stick);
        logic f;
        if (nine)
            f = extra;
        else if (!pen)
            f = 1'b0;
        else
            f = extra ^ expected_parity(d, even, stick);
        return f;
    endfunction

endpackage

// File: rtl/rxs_flag_gen.sv
module rxs_flag_gen
    import uart_rxs_pkg::*;
(
    input  logic [DW-1:0] data,
    input  logic          extra,
    input  logic          frame_err,
    input  logic          brk,
    input  logic          nine_bit,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          par_stick,
    output rxs_entry_t    entry
);

    always_comb begin
        entry.data      = data;
        entry.flags.frm = frame_err;
        entry.flags.brk = brk;
        entry.flags.par = parity_flag(data, extra, nine_bit, par_en,
                                      par_even, par_stick);
    end

endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             single_mode,
    input  logic             push_req,
    input  logic             pop_req,
    input  rxs_entry_t       din,
    output rxs_entry_t       head,
    output logic             empty,
    output logic             full,
    output logic             overflow,
    output logic [CNT_W-1:0] count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    rxs_entry_t       slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             pop_ok;
    logic             push_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        logic [PTR_W-1:0] n;
        if (p == PTR_W'(DEPTH - 1))
            n = '0;
        else
            n = p + 1'b1;
        return n;
    endfunction

    assign empty    = (count == '0);
    assign full     = single_mode ? !empty : (count == CNT_W'(DEPTH));
    assign pop_ok   = pop_req && !empty;
    assign push_ok  = push_req && (!full || pop_ok);
    assign overflow = push_req && full && !pop_ok;
    assign head     = slot[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok)
            slot[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)
                rd_ptr <= ptr_next(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxs_status_reg.sv
module rxs_status_reg
    import uart_rxs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        snap_en,
    input  rxs_flags_t  snap_flags,
    input  logic        clr,
    input  logic        ovr_set,
    output rxs_status_t status
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            if (clr)
                status.flags <= '0;
            else if (snap_en)
                status.flags <= snap_flags;

            if (ovr_set)
                status.ovr <= 1'b1;
            else if (clr)
                status.ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fifo_en,
    input  logic              cfg_nine_bit,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              rx_valid,
    input  logic [DW-1:0]     rx_data,
    input  logic              rx_extra,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd_en,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    rxs_entry_t       in_entry;
    rxs_entry_t       head;
    rxs_flags_t       head_flags;
    rxs_status_t      status_q;
    rxs_reg_e         sel;
    logic             fifo_empty;
    logic             fifo_full;
    logic             fifo_ovf;
    logic [CNT_W-1:0] fifo_count;
    logic             pop;
    logic             err_clr;
    logic             wdata_unused;

    function automatic rxs_reg_e decode(input logic [ADDR_W-1:0] a);
        rxs_reg_e r;
        if (a == ADDR_W'(OFS_DATA))
            r = REG_DATA;
        else if (a == ADDR_W'(OFS_STAT))
            r = REG_STAT;
        else
            r = REG_NONE;
        return r;
    endfunction

    assign wdata_unused = ^reg_wdata;
    assign sel          = decode(reg_addr);
    assign pop          = reg_rd_en && (sel == REG_DATA) && !fifo_empty;
    assign err_clr      = reg_wr_en && (sel == REG_STAT);
    assign head_flags   = head.flags;

    rxs_flag_gen u_flag_gen (
        .data      (rx_data),
        .extra     (rx_extra),
        .frame_err (rx_frame_err),
        .brk       (rx_break),
        .nine_bit  (cfg_nine_bit),
        .par_en    (cfg_par_en),
        .par_even  (cfg_par_even),
        .par_stick (cfg_par_stick),
        .entry     (in_entry)
    );

    rxs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .single_mode (!cfg_fifo_en),
        .push_req    (rx_valid),
        .pop_req     (pop),
        .din         (in_entry),
        .head        (head),
        .empty       (fifo_empty),
        .full        (fifo_full),
        .overflow    (fifo_ovf),
        .count       (fifo_count)
    );

    rxs_status_reg u_status (
        .clk        (clk),
        .rst        (rst),
        .snap_en    (pop),
        .snap_flags (head.flags),
        .clr        (err_clr),
        .ovr_set    (fifo_ovf),
        .status     (status_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_DATA: begin
                reg_rdata[11] = status_q.ovr;
                if (!fifo_empty)
                    reg_rdata[10:0] = {head.flags, head.data};
            end
            REG_STAT: reg_rdata[3:0] = status_q;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxs_checker.sv
module rxs_checker
    import uart_rxs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             rx_valid,
    input logic             full,
    input logic             empty,
    input logic             pop,
    input logic             clr,
    input logic             rd_en,
    input rxs_reg_e         sel,
    input rxs_status_t      status,
    input rxs_flags_t       head_flags,
    input logic [CNT_W-1:0] count,
    input logic [31:0]      rdata
);

    AST_SNAPSHOT_ON_POP: assert property (@(posedge clk) disable iff (rst)
        pop && !clr |=> status.flags == $past(head_flags)); // R3

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pop && !clr |=> $stable(status.flags)); // R3

    AST_OVERRUN_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        rx_valid && full && !pop |=> status.ovr); // R4

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        status.ovr && !clr |=> status.ovr); // R4

    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (rst)
        clr |=> status.flags == 3'b000); // R5

    AST_CLEAR_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        clr && !(rx_valid && full && !pop) |=> !status.ovr); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R2

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[31:12] == 20'h0); // R10

    AST_EMPTY_READ_STABLE: assert property (@(posedge clk) disable iff (rst)
        rd_en && sel == REG_DATA && empty && !clr && !rx_valid |=> $stable(status)); // R12

endmodule

bind uart_rx_status rxs_checker #(.DEPTH(DEPTH)) u_rxs_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_valid   (rx_valid),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .pop        (pop),
    .clr        (err_clr),
    .rd_en      (reg_rd_en),
    .sel        (sel),
    .status     (status_q),
    .head_flags (head_flags),
    .count      (fifo_count),
    .rdata      (reg_rdata)
);

// File: tb/tb_uart_rx_status.sv
`timescale 1ns/1ps
module tb_uart_rx_status;

    localparam int DEPTH = 16;
    localparam logic [3:0] A_DATA  = 4'h0;
    localparam logic [3:0] A_STAT  = 4'h4;
    localparam logic [3:0] A_OTHER = 4'h8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_fifo_en = 1'b1;
    logic        cfg_nine_bit = 1'b0;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_even = 1'b0;
    logic        cfg_par_stick = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_extra = 1'b0;
    logic        rx_frame_err = 1'b0;
    logic        rx_break = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_rd_en = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    uart_rx_status #(.DEPTH(DEPTH), .ADDR_W(4)) dut (
        .clk(clk), .rst(rst),
        .cfg_fifo_en(cfg_fifo_en), .cfg_nine_bit(cfg_nine_bit),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_extra(rx_extra),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break),
        .reg_addr(reg_addr), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic set_char(input logic [7:0] d, input logic x, input logic fe, input logic br);
        rx_data = d;
        rx_extra = x;
        rx_frame_err = fe;
        rx_break = br;
    endtask

    task automatic push(input logic [7:0] d, input logic x, input logic fe, input logic br);
        set_char(d, x, fe, br);
        rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        reg_rd_en = 1'b1;
        #1;
        v = reg_rdata;
        @(posedge clk);
        #1;
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a;
        reg_wdata = d;
        reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    function automatic logic exp_par(input logic [7:0] d, input logic x, input logic nine,
                                     input logic pen, input logic even, input logic stick);
        int ones = 0;
        logic want;
        for (int i = 0; i < 8; i++) ones += int'(d[i]);
        if (stick) want = even ? 1'b0 : 1'b1;
        else if (even) want = (ones % 2 == 1);
        else want = (ones % 2 == 0);
        if (nine) return x;
        if (!pen) return 1'b0;
        return x != want;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [2:0]  fl;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(A_STAT, v); check("R1 status after reset", v, 32'h0);
        rd(A_DATA, v); check("R1 data after reset", v, 32'h0);

        // Sweep: all characters under all parity / nine-bit settings (R2, R6, R7, R8)
        for (int c = 0; c < 16; c++) begin
            cfg_nine_bit  = c[3];
            cfg_par_en    = c[2];
            cfg_par_even  = c[1];
            cfg_par_stick = c[0];
            for (int d = 0; d < 256; d++) begin
                logic [7:0] dd;
                logic x, fe, br, p;
                string req;
                dd = 8'(d);
                x  = dd[3] ^ dd[7] ^ c[0];
                fe = dd[5];
                br = dd[6] & dd[1];
                p  = exp_par(dd, x, c[3], c[2], c[1], c[0]);
                req = c[3] ? "R8" : (c[0] && c[2]) ? "R7" : "R6";
                push(dd, x, fe, br);
                rd(A_DATA, v);
                check({"R2 data word ", req}, v, {20'h0, 1'b0, br, p, fe, dd});
                rd(A_STAT, v);
                check({"R3 status ", req}, v, {28'h0, 1'b0, br, p, fe});
            end
        end
        cfg_nine_bit = 1'b0; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_par_stick = 1'b0;

        // R5 clear with arbitrary data
        push(8'h01, 1'b0, 1'b1, 1'b1);
        rd(A_DATA, v);
        wr(A_STAT, 32'hDEADBEEF);
        rd(A_STAT, v); check("R5 clear ignores data", v, 32'h0);

        // R4 fill and overrun
        for (int i = 0; i < DEPTH; i++) push(8'(8'h40 + i), 1'b0, i[0], i == 5);
        rd(A_STAT, v); check("R4 no overrun at exact depth", v, 32'h0);
        push(8'hEE, 1'b0, 1'b1, 1'b1);
        rd(A_STAT, v); check("R4 overrun immediate", v, 32'h8);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R5 clear overrun", v, 32'h0);

        // R4 pop and arrival on same edge while full
        set_char(8'h99, 1'b0, 1'b0, 1'b0);
        rx_valid = 1'b1;
        reg_addr = A_DATA;
        reg_rd_en = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk); #1;
        rx_valid = 1'b0; reg_rd_en = 1'b0;
        check("R2 head while full", v, 32'h040);
        rd(A_STAT, v); check("R4 pop makes room", v, 32'h0);

        // R5 overrun and clear on same edge: overrun wins
        set_char(8'hEF, 1'b0, 1'b0, 1'b0);
        rx_valid = 1'b1;
        reg_addr = A_STAT;
        reg_wdata = 32'h5;
        reg_wr_en = 1'b1;
        tick();
        rx_valid = 1'b0; reg_wr_en = 1'b0;
        rd(A_STAT, v); check("R5 overrun set wins over clear", v, 32'h8);

        // R2 drain order, R4 stored contents kept
        for (int i = 1; i <= DEPTH; i++) begin
            logic [7:0] ed;
            if (i < DEPTH) begin
                ed = 8'(8'h40 + i);
                fl = {i == 5, 1'b0, i[0]};
            end else begin
                ed = 8'h99;
                fl = 3'b000;
            end
            rd(A_DATA, v);
            check("R2 drain order", v, {20'h0, 1'b1, fl, ed});
            rd(A_STAT, v);
            check("R3 status follows pop", v, {28'h0, 1'b1, fl});
        end

        // R12 empty read
        rd(A_DATA, v); check("R12 empty data read", v, 32'h800);
        rd(A_STAT, v); check("R12 status unchanged", v, 32'h8);
        wr(A_STAT, 32'hFFFFFFFF);
        rd(A_DATA, v); check("R12 empty after clear", v, 32'h0);

        // R3 status reflects popped char, not head
        push(8'h11, 1'b0, 1'b1, 1'b0);
        push(8'h22, 1'b0, 1'b0, 1'b1);
        rd(A_STAT, v); check("R3 no update without pop", v, 32'h0);
        rd(A_DATA, v); check("R2 first char", v, 32'h111);
        rd(A_STAT, v); check("R3 popped not head", v, 32'h1);
        rd(A_STAT, v); check("R3 stable on status read", v, 32'h1);
        rd(A_DATA, v); check("R2 second char", v, 32'h422);
        rd(A_STAT, v); check("R3 second snapshot", v, 32'h4);
        wr(A_STAT, 32'h0);

        // R9 flags fixed at arrival
        cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        push(8'h03, 1'b0, 1'b0, 1'b0);
        cfg_par_even = 1'b0;
        rd(A_DATA, v); check("R9 flag from arrival config", v, 32'h003);
        push(8'h03, 1'b0, 1'b0, 1'b0);
        cfg_nine_bit = 1'b1;
        rd(A_DATA, v); check("R9 odd parity error kept", v, 32'h203);
        cfg_nine_bit = 1'b0; cfg_par_en = 1'b0;
        rd(A_STAT, v); check("R9 status", v, 32'h2);

        // R10 other offsets
        push(8'h5A, 1'b0, 1'b0, 1'b0);
        wr(A_DATA, 32'hFFFFFFFF);
        wr(A_OTHER, 32'hFFFFFFFF);
        rd(A_STAT, v); check("R10 writes elsewhere ignored", v, 32'h2);
        rd(A_OTHER, v); check("R10 unmapped read", v, 32'h0);
        rd(A_DATA, v); check("R10 buffer untouched", v, 32'h05A);
        rd(A_DATA, v); check("R10 only one char", v, 32'h0);

        // R11 FIFO disabled
        cfg_fifo_en = 1'b0;
        push(8'h31, 1'b0, 1'b0, 1'b0);
        rd(A_STAT, v); check("R11 single slot no overrun", v, 32'h0);
        push(8'h32, 1'b0, 1'b0, 1'b0);
        rd(A_STAT, v); check("R11 second char overruns", v, 32'h8);
        rd(A_DATA, v); check("R11 first char kept", v, 32'h831);
        rd(A_DATA, v); check("R11 second discarded", v, 32'h800);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R5 final clear", v, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule